// File: doc/BRIEF.md
# Cascadable Load/Shift Register with Output Gating

This block is a shift register built from a configurable number of 4-bit sections placed end to end. A mode input selects between two operations. In load mode every bit is replaced from a parallel input bus. In shift mode the contents move one place toward the far end, and a serial input bit enters at the near end. All updates happen on the falling edge of the clock. An asynchronous active-low clear empties the register at any time.

The parallel contents leave the block as a value bus together with a per-bit drive flag. The drive flag follows an active-low output enable, so a pad ring or bus wrapper can float the lines without any tristate inside the core. A single serial tap on the last bit is always driven and does not depend on the output enable. Connecting this tap to the serial input of another instance extends the chain.

Top module: `casc_shift_reg`

## Requirements
- R1: The register changes only on the falling edge of `clk`. A rising edge, or a change of inputs between falling edges, leaves `q_val` unchanged.
- R2: If `load_en` is 1 at a falling edge, `q_val` becomes `par_in`. Section k occupies bits [4k+3:4k], and bit 4k is that section's first stage.
- R3: If `load_en` is 0 at a falling edge, bit 0 takes `ser_in`, each bit i>0 takes the old bit i-1, and the old top bit is discarded.
- R4: While `rst_n` is 0, `q_val` and `ser_out` are 0 at once, without waiting for a clock edge. This holds whatever the mode, data or enable inputs are.
- R5: `q_drv` is all ones when `out_en_n` is 0 and all zeros when it is 1. Toggling `out_en_n` never alters the stored contents seen on `q_val`.
- R6: `ser_out` always equals the top bit `q_val[4*STAGES-1]`, and it does not depend on `out_en_n`.
- R7: In shift mode the first stage of section k takes the last stage of section k-1. A bit presented on `ser_in` therefore reaches `ser_out` after exactly 4*STAGES falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on its falling edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_en | input | 1 | 1 = parallel load, 0 = shift toward the top bit |
| ser_in | input | 1 | Serial bit taken into bit 0 when shifting |
| par_in | input | 4*STAGES | Parallel data; section k on bits [4k+3:4k] |
| out_en_n | input | 1 | Active-low enable for the parallel outputs |
| q_val | output | 4*STAGES | Stored contents |
| q_drv | output | 4*STAGES | Per-bit drive flag; 0 means the line floats |
| ser_out | output | 1 | Last stage, always driven, for chaining |

## Verification
The loads use alternating, all-ones, all-zeros and mixed words. These show whether each section's slice lands in its own place and in the right bit order. The shifts take irregular serial patterns: a swapped or skipped bit link, or a wrong entry bit, shows up as a mismatch in the first cycle it occurs, and a full pass of 4*STAGES bits checks the links between sections. The output enable is toggled during shifting, which separates gating of the drive flags from any effect on the contents or the serial tap. A clear is applied in the middle of a shift and held across a load edge, which shows that it acts at once and overrides the mode.

// File: rtl/casc_shift_reg.sv
module casc_shift_reg #(
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic                  ser_in,
  input  logic [4*STAGES-1:0]   par_in,
  input  logic                  out_en_n,
  output logic [4*STAGES-1:0]   q_val,
  output logic [4*STAGES-1:0]   q_drv,
  output logic                  ser_out
);
  localparam int W = 4 * STAGES;

  logic [W-1:0] cells;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       cells <= '0;
    else if (load_en) cells <= par_in;
    else              cells <= {cells[W-2:0], ser_in};
  end

  assign q_val   = cells;
  assign q_drv   = {W{~out_en_n}};
  assign ser_out = cells[W-1];
endmodule

module casc_shift_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_en,
  input logic         ser_in,
  input logic [W-1:0] par_in,
  input logic         out_en_n,
  input logic [W-1:0] q_val,
  input logic [W-1:0] q_drv,
  input logic         ser_out
);
  AST_LOAD_TAKES_BUS: assert property (@(negedge clk) disable iff (!rst_n)
    load_en |=> q_val == $past(par_in)); // R2

  AST_SHIFT_ONE_PLACE: assert property (@(negedge clk) disable iff (!rst_n)
    !load_en |=> q_val == {$past(q_val[W-2:0]), $past(ser_in)}); // R3

  AST_TAIL_FOLLOWS_CHAIN: assert property (@(negedge clk) disable iff (!rst_n)
    !load_en |=> ser_out == $past(q_val[W-2])); // R7

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_CLEAR_HOLDS: assert (q_val == '0 && ser_out == 1'b0); // R4
    end
  end
endmodule

bind casc_shift_reg casc_shift_reg_chk #(.W(4*STAGES)) u_chk (.*);

// File: tb/test_casc_shift_reg.sv
module test_casc_shift_reg;
  localparam int STAGES = 2;
  localparam int W = 4 * STAGES;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         load_en = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         out_en_n = 1'b0;
  logic [W-1:0] q_val, q_drv;
  logic         ser_out;

  casc_shift_reg #(.STAGES(STAGES)) i_casc_shift_reg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .ser_in(ser_in),
    .par_in(par_in), .out_en_n(out_en_n), .q_val(q_val), .q_drv(q_drv),
    .ser_out(ser_out)
  );

  always #4 clk = ~clk;

  bit    mdl[$];
  string req_tag = "R4";
  int    checks = 0;
  int    fails = 0;
  bit    chk_on = 0;
  bit    done = 0;

  function automatic logic [W-1:0] mdl_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = mdl[i];
    return v;
  endfunction

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl.delete();
      for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    end else if (load_en) begin
      mdl.delete();
      for (int i = 0; i < W; i++) mdl.push_back(par_in[i]);
    end else begin
      mdl.push_front(ser_in);
      void'(mdl.pop_back());
    end
  end

  task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    chk(req_tag, "q_val", q_val, mdl_word());
    chk("R5", "q_drv", q_drv, out_en_n ? '0 : '1);
    chk("R6", "ser_out", W'(ser_out), W'(mdl[W-1]));
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_on && !done) compare_all();
  end

  task automatic step(logic le, logic si, logic oen, logic [W-1:0] d);
    @(posedge clk);
    #2;
    load_en = le; ser_in = si; out_en_n = oen; par_in = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] pat;
    logic         first_bit;
    for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    #1 rst_n = 1'b0;
    #1 chk_on = 1;
    // R4: reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R4", "q_val in reset", q_val, '0);
    chk("R4", "ser_out in reset", W'(ser_out), '0);
    #1 rst_n = 1'b1;

    // R2: parallel loads with distinct words
    req_tag = "R2";
    step(1, 0, 0, 8'hA5);
    step(1, 1, 0, 8'h3C);
    // R1: rising edge and mid-cycle input change leave contents alone
    #1 chk("R1", "before falling edge", q_val, 8'hA5);
    step(1, 0, 0, 8'hFF);
    step(1, 1, 0, 8'h00);
    step(1, 0, 0, 8'h96);

    // R3: shifting with an irregular serial pattern
    req_tag = "R3";
    pat = 8'b1101_0011;
    for (int i = 0; i < W; i++) step(0, pat[i], 0, 8'h5A);

    // R7: full pass through all sections
    req_tag = "R7";
    step(1, 0, 0, 8'h00);
    pat = 8'b1011_0010;
    first_bit = 1'b1;
    step(0, first_bit, 0, 8'hFF);
    for (int i = 1; i < W; i++) step(0, pat[i], 0, 8'hFF);
    @(negedge clk);
    #1 chk("R7", "first bit at ser_out", W'(ser_out), W'(first_bit));
    for (int i = 0; i < W; i++) step(0, 1'b0, 0, 8'hFF);

    // R5 and R6: toggle output enable while shifting
    req_tag = "R5";
    step(1, 0, 0, 8'hC3);
    for (int i = 0; i < 2 * W; i++) step(0, i[0] ^ i[2], i[0], 8'h00);
    req_tag = "R6";
    for (int i = 0; i < W; i++) step(0, i[1], 1, 8'h00);

    // R4: clear during a shift, held across a load edge
    req_tag = "R3";
    step(1, 0, 0, 8'h7E);
    step(0, 1, 0, 8'h00);
    step(0, 1, 0, 8'h00);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R4", "async clear mid-shift", q_val, '0);
    req_tag = "R4";
    load_en = 1'b1; par_in = 8'hFF;
    @(negedge clk);
    #1 chk("R4", "clear beats load", q_val, '0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    req_tag = "R2";
    step(1, 0, 0, 8'h81);
    step(0, 1, 0, 8'h00);
    req_tag = "R3";
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule